// File: doc/BRIEF.md
# Display Common Scan Sequencer

This block produces the row scan for a matrix display of 32 graphic rows plus one icon row. It advances one scan slot per clock-enable tick and reports which common line is active, which display RAM line feeds that slot, a frame parity bit used for drive alternation, and a segment policy code. The segment policy code tells the segment stage whether to pass RAM data, invert it, force every pixel on, or blank.

The scan can run at a 33-slot frame or a 17-slot frame. In the long frame it can walk the rows in plain numerical order, or interleave the upper and lower halves. A start-line value rotates the RAM mapping for vertical scrolling. One combination of the display state bits puts the block into a power-save state. In that state the scan freezes and all outputs are held at their idle level.

All outputs are registered. Every output reflects the slot counter and the state inputs one clock after they change.

Top module: `com_scan_seq`

## Requirements
- R1: While `rst` is high, `com_valid`=0, `com_idx`=0, `ram_line`=0, `icon_row`=0, `frame_tog`=0, `power_save`=0 and `seg_mode`=3 (blank).
- R2: With `short_duty`=0 and `alt_order`=0, each accepted tick advances the slot. The slot order is `com_idx` 0,1,…,31 (common rows 1 to 32), then 32 (both icon commons together, with `icon_row`=1), then back to 0.
- R3: With `short_duty`=0 and `alt_order`=1, the 33-slot order is 0,16,1,17,…,15,31 and then 32 (icon).
- R4: With `short_duty`=1, the frame has 17 slots, 0..15 followed by 32 (icon), and `alt_order` has no effect.
- R5: In a graphic slot, `ram_line` = (`start_line` + row index) mod 64. In the icon slot, `ram_line`=0 and `icon_row`=1.
- R6: `frame_tog` inverts exactly once per frame, when the slot wraps from the last slot to slot 0.
- R7: `disp_on`=0 together with `all_lit`=1 gives `power_save`=1, `com_valid`=0 and `seg_mode`=3. While this holds, ticks are ignored. When the state is left, the scan resumes at the same slot.
- R8: `seg_mode` encoding is 0 = pass data, 1 = invert data (RAM 0 lights), 2 = all on, 3 = blank. `disp_on`=0 gives 3 while scanning continues. With `disp_on`=1, `all_lit`=1 gives 2; otherwise `reverse`=1 gives 1, and `reverse`=0 gives 0.
- R9: With `icon_only`=1 (display on, all-lit off), graphic slots give `seg_mode`=3. The icon slot follows the `reverse` setting. `all_lit`=1 overrides the icon-only blanking.
- R10: If the slot is beyond the short frame when `short_duty` is set, that slot maps to the icon common. The next tick wraps to slot 0 and inverts `frame_tog`.
- R11: Without a tick, the slot, `com_idx` and `frame_tog` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Scan clock enable, one slot per pulse |
| short_duty | input | 1 | 1 = 17-slot frame, 0 = 33-slot frame |
| alt_order | input | 1 | Interleave the two row halves (long frame only) |
| start_line | input | 6 | RAM line shown on the first row |
| disp_on | input | 1 | Display enabled |
| all_lit | input | 1 | Force all pixels on |
| reverse | input | 1 | Pixel lit by RAM 0 |
| icon_only | input | 1 | Show only the icon row |
| com_idx | output | 6 | Active common: 0..31 rows, 32 icon pair |
| com_valid | output | 1 | A common is being driven |
| ram_line | output | 6 | RAM line for the active slot |
| icon_row | output | 1 | Active slot is the icon row |
| frame_tog | output | 1 | Frame parity for alternation |
| power_save | output | 1 | Power-save state |
| seg_mode | output | 2 | Segment policy code |

## Verification
A corrupted slot counter shows up on `com_idx` and `ram_line` one clock after the tick that advanced it. It also moves the frame parity flip away from the wrap, which appears at most one frame later. A wrong row mapping shows up in the first slot whose row index differs between the two orders, which is slot 1 in interleaved mode. Faulty state decoding shows up on `seg_mode` and `power_save` one clock after the state inputs change. A counter that drifts while frozen shows up as a different `com_idx` right after power save is left.

// File: rtl/com_scan_pkg.sv
package com_scan_pkg;
  typedef enum logic [1:0] {
    SEG_DATA   = 2'd0,
    SEG_INVERT = 2'd1,
    SEG_ALL_ON = 2'd2,
    SEG_BLANK  = 2'd3
  } seg_mode_e;
endpackage

// File: rtl/com_slot_counter.sv
module com_slot_counter #(
  parameter int ROWS = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic                         hold,
  input  logic                         short_duty,
  output logic [$clog2(ROWS+1)-1:0]    slot,
  output logic                         frame
);
  localparam int SLOT_W = $clog2(ROWS+1);
  localparam logic [SLOT_W-1:0] LAST_LONG  = SLOT_W'(ROWS);
  localparam logic [SLOT_W-1:0] LAST_SHORT = SLOT_W'(ROWS/2);

  logic [SLOT_W-1:0] last_slot;
  assign last_slot = short_duty ? LAST_SHORT : LAST_LONG;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot  <= '0;
      frame <= 1'b0;
    end else if (tick && !hold) begin
      if (slot >= last_slot) begin
        slot  <= '0;
        frame <= ~frame;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  // R2: slot never leaves the long frame
  a_r2_slot_range: assert property (@(posedge clk) disable iff (rst)
    slot <= LAST_LONG);

  // R6: parity only changes on the wrap to slot 0
  a_r6_flip_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (frame != $past(frame)) |-> (slot == '0));

  // R7: frozen while held
  a_r7_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(slot));

  // R11: no tick, no movement
  a_r11_no_tick_stable: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(slot) && $stable(frame)));
endmodule

// File: rtl/com_order_map.sv
module com_order_map #(
  parameter int ROWS   = 32,
  parameter int LINE_W = 6
) (
  input  logic [$clog2(ROWS+1)-1:0] slot,
  input  logic                      short_duty,
  input  logic                      alt_order,
  input  logic [LINE_W-1:0]         start_line,
  output logic [$clog2(ROWS+1)-1:0] com_idx,
  output logic                      is_icon,
  output logic [LINE_W-1:0]         ram_line
);
  localparam int SLOT_W = $clog2(ROWS+1);
  localparam int ROW_W  = $clog2(ROWS);
  localparam logic [ROW_W-1:0]  HALF_R     = ROW_W'(ROWS/2);
  localparam logic [SLOT_W-1:0] ICON_IDX   = SLOT_W'(ROWS);
  localparam logic [SLOT_W-1:0] SHORT_ICON = SLOT_W'(ROWS/2);

  logic [ROW_W-1:0] row;

  always_comb begin
    is_icon = short_duty ? (slot >= SHORT_ICON) : (slot >= ICON_IDX);
    if (!short_duty && alt_order)
      row = slot[0] ? (HALF_R + slot[ROW_W:1]) : slot[ROW_W:1];
    else
      row = slot[ROW_W-1:0];
    if (is_icon) begin
      com_idx  = ICON_IDX;
      ram_line = '0;
    end else begin
      com_idx  = SLOT_W'(row);
      ram_line = start_line + LINE_W'(row);
    end
  end
endmodule

// File: rtl/com_seg_policy.sv
module com_seg_policy
  import com_scan_pkg::*;
(
  input  logic      disp_on,
  input  logic      all_lit,
  input  logic      reverse,
  input  logic      icon_only,
  input  logic      is_icon,
  output logic      power_save,
  output seg_mode_e seg_mode
);
  always_comb begin
    power_save = !disp_on && all_lit;
    if (!disp_on)
      seg_mode = SEG_BLANK;
    else if (all_lit)
      seg_mode = SEG_ALL_ON;
    else if (icon_only && !is_icon)
      seg_mode = SEG_BLANK;
    else if (reverse)
      seg_mode = SEG_INVERT;
    else
      seg_mode = SEG_DATA;
  end
endmodule

// File: rtl/com_scan_seq.sv
module com_scan_seq
  import com_scan_pkg::*;
#(
  parameter int ROWS   = 32,
  parameter int LINE_W = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic                      short_duty,
  input  logic                      alt_order,
  input  logic [LINE_W-1:0]         start_line,
  input  logic                      disp_on,
  input  logic                      all_lit,
  input  logic                      reverse,
  input  logic                      icon_only,
  output logic [$clog2(ROWS+1)-1:0] com_idx,
  output logic                      com_valid,
  output logic [LINE_W-1:0]         ram_line,
  output logic                      icon_row,
  output logic                      frame_tog,
  output logic                      power_save,
  output logic [1:0]                seg_mode
);
  localparam int SLOT_W = $clog2(ROWS+1);
  localparam logic [SLOT_W-1:0] ICON_IDX = SLOT_W'(ROWS);

  logic [SLOT_W-1:0] slot_c, idx_c;
  logic              frame_c, icon_c, ps_c;
  logic [LINE_W-1:0] line_c;
  seg_mode_e         mode_c;

  com_slot_counter #(.ROWS(ROWS)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .hold(ps_c),
    .short_duty(short_duty), .slot(slot_c), .frame(frame_c)
  );

  com_order_map #(.ROWS(ROWS), .LINE_W(LINE_W)) u_map (
    .slot(slot_c), .short_duty(short_duty), .alt_order(alt_order),
    .start_line(start_line), .com_idx(idx_c), .is_icon(icon_c),
    .ram_line(line_c)
  );

  com_seg_policy u_pol (
    .disp_on(disp_on), .all_lit(all_lit), .reverse(reverse),
    .icon_only(icon_only), .is_icon(icon_c),
    .power_save(ps_c), .seg_mode(mode_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      com_idx    <= '0;
      com_valid  <= 1'b0;
      ram_line   <= '0;
      icon_row   <= 1'b0;
      frame_tog  <= 1'b0;
      power_save <= 1'b0;
      seg_mode   <= SEG_BLANK;
    end else begin
      com_idx    <= idx_c;
      com_valid  <= !ps_c;
      ram_line   <= line_c;
      icon_row   <= icon_c;
      frame_tog  <= frame_c;
      power_save <= ps_c;
      seg_mode   <= mode_c;
    end
  end

  // R7: no common is driven in power save
  a_r7_ps_idle: assert property (@(posedge clk) disable iff (rst)
    power_save |-> (!com_valid && seg_mode == SEG_BLANK));

  // R5: icon slot reports the icon common
  a_r5_icon_index: assert property (@(posedge clk) disable iff (rst)
    icon_row |-> (com_idx == ICON_IDX && ram_line == '0));

  // R2: reported common within range
  a_r2_idx_range: assert property (@(posedge clk) disable iff (rst)
    com_idx <= ICON_IDX);
endmodule

// File: tb/com_scan_seq_tb.sv
`timescale 1ns/1ps
module com_scan_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic short_duty = 1'b0, alt_order = 1'b0;
  logic [5:0] start_line = '0;
  logic disp_on = 1'b1, all_lit = 1'b0, reverse = 1'b0, icon_only = 1'b0;
  logic [5:0] com_idx, ram_line;
  logic com_valid, icon_row, frame_tog, power_save;
  logic [1:0] seg_mode;

  int n_cmp = 0, n_bad = 0;
  int es = 0;
  int ef = 0;

  always #2.5 clk = ~clk;

  com_scan_seq u_dut (
    .clk(clk), .rst(rst), .tick(tick), .short_duty(short_duty),
    .alt_order(alt_order), .start_line(start_line), .disp_on(disp_on),
    .all_lit(all_lit), .reverse(reverse), .icon_only(icon_only),
    .com_idx(com_idx), .com_valid(com_valid), .ram_line(ram_line),
    .icon_row(icon_row), .frame_tog(frame_tog), .power_save(power_save),
    .seg_mode(seg_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_idx(input int s, input bit sh, input bit al);
    if (sh) return (s >= 16) ? 32 : s;
    if (s >= 32) return 32;
    if (al) return (s % 2 == 1) ? 16 + s / 2 : s / 2;
    return s;
  endfunction

  task automatic step();
    int last;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
    last = short_duty ? 16 : 32;
    if (!(!disp_on && all_lit)) begin
      if (es >= last) begin es = 0; ef = 1 - ef; end
      else es = es + 1;
    end
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    es = 0; ef = 0;
    settle();
  endtask

  task automatic t_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 com_valid", com_valid, 0);
    chk("R1 com_idx", com_idx, 0);
    chk("R1 ram_line", ram_line, 0);
    chk("R1 icon_row", icon_row, 0);
    chk("R1 frame_tog", frame_tog, 0);
    chk("R1 power_save", power_save, 0);
    chk("R1 seg_mode", seg_mode, 3);
    rst = 1'b0; es = 0; ef = 0;
    settle();
  endtask

  task automatic t_numeric();
    short_duty = 0; alt_order = 0; start_line = 0;
    do_reset();
    for (int k = 0; k < 34; k++) begin
      chk("R2 numeric com_idx", com_idx, (k == 32) ? 32 : k % 33);
      chk("R2 icon_row", icon_row, (k == 32) ? 1 : 0);
      step();
    end
  endtask

  task automatic t_alternate();
    short_duty = 0; alt_order = 1; start_line = 0;
    do_reset();
    for (int k = 0; k < 33; k++) begin
      int e;
      e = (k == 32) ? 32 : ((k % 2 == 1) ? 16 + k / 2 : k / 2);
      chk("R3 interleaved com_idx", com_idx, e);
      step();
    end
    chk("R3 wrap to first", com_idx, 0);
  endtask

  task automatic t_short();
    short_duty = 1; alt_order = 1; start_line = 0;
    do_reset();
    for (int k = 0; k < 18; k++) begin
      chk("R4 short com_idx", com_idx, (k == 16) ? 32 : k % 17);
      step();
    end
    chk("R4 frame flipped once", frame_tog, 1);
    short_duty = 0; alt_order = 0;
  endtask

  task automatic t_ramline();
    short_duty = 0; alt_order = 0; start_line = 6'd60;
    do_reset();
    for (int k = 0; k < 33; k++) begin
      chk("R5 ram_line", ram_line, (k == 32) ? 0 : (60 + k) % 64);
      step();
    end
    alt_order = 1; start_line = 6'd5;
    do_reset();
    step();
    chk("R5 alt row16 line", ram_line, 21);
    alt_order = 0; start_line = 0;
  endtask

  task automatic t_frame();
    do_reset();
    for (int k = 0; k < 66; k++) begin
      step();
      chk("R6 frame_tog", frame_tog, ef);
    end
  endtask

  task automatic t_powersave();
    do_reset();
    repeat (5) step();
    @(negedge clk) begin disp_on = 0; all_lit = 1; end
    settle();
    chk("R7 power_save", power_save, 1);
    chk("R7 com_valid", com_valid, 0);
    chk("R7 seg_mode", seg_mode, 3);
    repeat (3) step();
    @(negedge clk) begin disp_on = 1; all_lit = 0; end
    settle();
    chk("R7 resume slot", com_idx, 5);
    chk("R7 power_save cleared", power_save, 0);
    chk("R7 com_valid back", com_valid, 1);
  endtask

  task automatic t_segmode();
    do_reset();
    chk("R8 data", seg_mode, 0);
    @(negedge clk) reverse = 1; settle();
    chk("R8 invert", seg_mode, 1);
    @(negedge clk) all_lit = 1; settle();
    chk("R8 all on", seg_mode, 2);
    @(negedge clk) begin all_lit = 0; disp_on = 0; end
    settle();
    chk("R8 off blank", seg_mode, 3);
    chk("R8 off still scans", com_valid, 1);
    step();
    chk("R8 off slot advances", com_idx, 1);
    @(negedge clk) begin disp_on = 1; reverse = 0; end
    settle();
  endtask

  task automatic t_icononly();
    do_reset();
    @(negedge clk) begin icon_only = 1; reverse = 1; end
    settle();
    chk("R9 graphic blank", seg_mode, 3);
    repeat (32) step();
    chk("R9 icon slot idx", com_idx, 32);
    chk("R9 icon follows reverse", seg_mode, 1);
    step();
    @(negedge clk) all_lit = 1; settle();
    chk("R9 all-lit override", seg_mode, 2);
    @(negedge clk) begin all_lit = 0; icon_only = 0; reverse = 0; end
    settle();
  endtask

  task automatic t_shrink();
    short_duty = 0; alt_order = 0;
    do_reset();
    repeat (20) step();
    chk("R10 long slot 20", com_idx, 20);
    @(negedge clk) short_duty = 1; settle();
    chk("R10 beyond short is icon", com_idx, exp_idx(es, 1, 0));
    step();
    chk("R10 wrap slot", com_idx, 0);
    chk("R10 wrap frame", frame_tog, 1);
    short_duty = 0;
  endtask

  task automatic t_notick();
    do_reset();
    repeat (7) step();
    repeat (10) @(negedge clk);
    chk("R11 idx held", com_idx, 7);
    chk("R11 frame held", frame_tog, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_numeric();
    t_alternate();
    t_short();
    t_ramline();
    t_frame();
    t_powersave();
    t_segmode();
    t_icononly();
    t_shrink();
    t_notick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule